// File: doc/BRIEF.md
# Token-Passing Serial Frame Readout

This block is the readout controller of one front-end chip. Several such chips share a single serial data line, and they sit on a daisy chain. A token starts at the acquisition system and goes from chip to chip. A chip that receives the token drives the shared line and shifts out its event frame. When the frame is complete, it releases the line and hands the token to the next chip in the chain.

The frame starts with the chip's identifier. One block of data follows for each event column that was filled during acquisition. A block holds the column's bunch-crossing number, then a time word and a charge word for every channel. Each time and charge word carries a hit flag and a gain flag. The event storage sits outside the block and is read through an asynchronous read port.

Top module: `chain_readout`

## Requirements
- R1: After reset, `tx_en`, `serial_out`, `token_out` and `readout_done` are all low.
- R2: A high `token_in` sampled while the block is idle starts a frame. From the next cycle, `tx_en` is high and the ID_W bits of `chip_id` (sampled with the token) appear on `serial_out`, most significant bit first, one bit per clock.
- R3: Each column c is sent as follows, with every word taken from address c*(1+2*N_CH)+k. First comes the low VAL_W bits of word k=0, which is the bunch-crossing number. Then, for each channel n, word k=1+2n (time) and then word k=2+2n (charge) are sent as all VAL_W+2 bits, ordered hit flag, gain flag, then the value, MSB first.
- R4: Only the first `col_count` columns, sampled with the token, are sent. With `col_count` = 0, the frame is the chip ID alone. The frame length in bits is ID_W + col_count*(VAL_W + 2*N_CH*(VAL_W+2)).
- R5: `tx_en` is high exactly for the cycles that carry frame bits. `serial_out` is low whenever `tx_en` is low.
- R6: In the cycle after the last frame bit, `token_out` and `readout_done` pulse high for exactly one cycle.
- R7: A `token_in` pulse that arrives while a frame is being sent has no effect on the frame bits or the frame length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| token_in | input | 1 | Token from the previous chip or from the acquisition system |
| chip_id | input | ID_W | Identifier of this chip |
| col_count | input | CNT_W | Number of filled columns |
| rd_addr | output | AW | Storage read address |
| rd_data | input | VAL_W+2 | Storage read data, asynchronous to `rd_addr` |
| serial_out | output | 1 | Shared serial data line |
| tx_en | output | 1 | Line drive enable, high while the token is held |
| token_out | output | 1 | Token to the next chip |
| readout_done | output | 1 | End-of-readout pulse |

## Verification
The bench sweeps every filled-column count from zero to the full depth. It repeats the sweep for chip IDs with all ones, all zeros and alternating patterns. The empty-column frames isolate the ID path and the token hand-off. The multi-column frames show whether the addresses advance correctly across column boundaries and whether the 12-bit bunch-crossing words are told apart from the 14-bit measurement words. The storage holds an address-dependent pattern, so a skipped or repeated word changes the bit stream. Some frames receive an extra token in mid-frame, which shows whether the block stays busy and ignores it.

// File: rtl/chain_readout.sv
module chain_readout #(
  parameter int ID_W  = 8,
  parameter int VAL_W = 12,
  parameter int N_CH  = 36,
  parameter int N_COL = 16,
  localparam int WPC   = 1 + 2*N_CH,
  localparam int DEPTH = N_COL*WPC,
  localparam int AW    = $clog2(DEPTH+1),
  localparam int CNT_W = $clog2(N_COL+1),
  localparam int SH_W  = VAL_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             token_in,
  input  logic [ID_W-1:0]  chip_id,
  input  logic [CNT_W-1:0] col_count,
  output logic [AW-1:0]    rd_addr,
  input  logic [SH_W-1:0]  rd_data,
  output logic             serial_out,
  output logic             tx_en,
  output logic             token_out,
  output logic             readout_done
);
  localparam int BW  = $clog2(SH_W+1);
  localparam int WIW = $clog2(WPC);

  logic            busy, tok_q;
  logic [SH_W-1:0] shreg;
  logic [BW-1:0]   bits_left;
  logic [AW-1:0]   waddr, wlast, total;
  logic [WIW-1:0]  widx;
  logic [CNT_W-1:0] cols_eff;

  assign cols_eff     = (col_count > CNT_W'(N_COL)) ? CNT_W'(N_COL) : col_count;
  assign total        = AW'(cols_eff) * AW'(WPC);
  assign rd_addr      = waddr;
  assign tx_en        = busy;
  assign serial_out   = busy & shreg[SH_W-1];
  assign token_out    = tok_q;
  assign readout_done = tok_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      tok_q     <= 1'b0;
      shreg     <= '0;
      bits_left <= '0;
      waddr     <= '0;
      wlast     <= '0;
      widx      <= '0;
    end else begin
      tok_q <= 1'b0;
      if (!busy) begin
        if (token_in) begin
          busy      <= 1'b1;
          shreg     <= {chip_id, {(SH_W-ID_W){1'b0}}};
          bits_left <= BW'(ID_W);
          waddr     <= '0;
          wlast     <= total;
          widx      <= '0;
        end
      end else if (bits_left != BW'(1)) begin
        shreg     <= shreg << 1;
        bits_left <= bits_left - 1'b1;
      end else if (waddr == wlast) begin
        busy  <= 1'b0;
        tok_q <= 1'b1;
        shreg <= '0;
      end else begin
        if (widx == '0) begin
          shreg     <= {rd_data[VAL_W-1:0], 2'b00};
          bits_left <= BW'(VAL_W);
        end else begin
          shreg     <= rd_data;
          bits_left <= BW'(SH_W);
        end
        waddr <= waddr + 1'b1;
        widx  <= (widx == WIW'(WPC-1)) ? '0 : widx + 1'b1;
      end
    end
  end
endmodule

module chain_readout_chk (
  input logic clk,
  input logic rst_n,
  input logic token_in,
  input logic serial_out,
  input logic tx_en,
  input logic token_out,
  input logic readout_done
);
  // R5
  line_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> !serial_out);
  // R2
  token_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (token_in && !tx_en) |=> tx_en);
  // R6
  token_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_en) |-> (token_out && readout_done));
  // R6
  token_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    token_out |=> !token_out);
  // R6
  token_needs_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(token_out) |-> (!tx_en && $past(tx_en)));
endmodule

bind chain_readout chain_readout_chk chk_i (
  .clk(clk), .rst_n(rst_n), .token_in(token_in), .serial_out(serial_out),
  .tx_en(tx_en), .token_out(token_out), .readout_done(readout_done)
);

// File: tb/chain_readout_tb_top.sv
module chain_readout_tb_top;
  localparam int ID_W = 8, VAL_W = 12, N_CH = 2, N_COL = 3;
  localparam int WPC = 1 + 2*N_CH, DEPTH = N_COL*WPC;
  localparam int AW = $clog2(DEPTH+1), CNT_W = $clog2(N_COL+1), SH_W = VAL_W+2;

  logic clk = 1'b0, rst_n = 1'b0, token_in = 1'b0;
  logic [ID_W-1:0] chip_id = '0;
  logic [CNT_W-1:0] col_count = '0;
  logic [AW-1:0] rd_addr;
  logic [SH_W-1:0] rd_data;
  logic serial_out, tx_en, token_out, readout_done;
  int checks = 0, errors = 0;
  bit finished = 0;
  logic exp_bits [0:1023];
  logic got_bits [0:1023];

  always #10 clk = ~clk;

  function automatic logic [SH_W-1:0] mem_val(int a);
    return SH_W'((a*613 + 77) % (1 << SH_W));
  endfunction
  assign rd_data = (int'(rd_addr) < DEPTH) ? mem_val(int'(rd_addr)) : '0;

  chain_readout #(.ID_W(ID_W), .VAL_W(VAL_W), .N_CH(N_CH), .N_COL(N_COL)) dut_i (
    .clk(clk), .rst_n(rst_n), .token_in(token_in), .chip_id(chip_id),
    .col_count(col_count), .rd_addr(rd_addr), .rd_data(rd_data),
    .serial_out(serial_out), .tx_en(tx_en), .token_out(token_out),
    .readout_done(readout_done));

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic run_frame(logic [ID_W-1:0] id, int cols, bit disturb);
    int len = 0, n = 0, bad_id = 0, bad_dat = 0;
    for (int b = ID_W-1; b >= 0; b--) begin exp_bits[len] = id[b]; len++; end
    for (int c = 0; c < cols; c++)
      for (int k = 0; k < WPC; k++) begin
        logic [SH_W-1:0] w = mem_val(c*WPC + k);
        int top = (k == 0) ? VAL_W-1 : SH_W-1;
        for (int b = top; b >= 0; b--) begin exp_bits[len] = w[b]; len++; end
      end
    @(negedge clk);
    check(!tx_en && !serial_out && !token_out, "R5 idle line", int'(tx_en), 0);
    chip_id = id; col_count = CNT_W'(cols); token_in = 1'b1;
    @(negedge clk);
    token_in = 1'b0; chip_id = ~id; col_count = '0;
    check(tx_en == 1'b1, "R2 frame start", int'(tx_en), 1);
    while (tx_en && n < 1000) begin
      got_bits[n] = serial_out;
      n++;
      token_in = (disturb && n == 20);
      @(negedge clk);
    end
    token_in = 1'b0;
    check(token_out && readout_done, "R6 token pulse", int'(token_out), 1);
    check(n == len, disturb ? "R7 length with extra token" : "R4 frame length", n, len);
    for (int i = 0; i < len && i < n; i++)
      if (got_bits[i] !== exp_bits[i]) begin
        if (i < ID_W) bad_id++; else bad_dat++;
      end
    check(bad_id == 0, "R2 chip id bits", bad_id, 0);
    check(bad_dat == 0, disturb ? "R7 data bits with extra token" : "R3 data bits", bad_dat, 0);
    @(negedge clk);
    check(!token_out && !readout_done && !tx_en, "R6 single pulse", int'(token_out), 0);
  endtask

  initial begin
    logic [ID_W-1:0] ids [4];
    ids[0] = 8'hA5; ids[1] = 8'h00; ids[2] = 8'hFF; ids[3] = 8'h3C;
    repeat (3) @(negedge clk);
    check(!tx_en && !serial_out && !token_out && !readout_done, "R1 reset state", int'(tx_en), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!tx_en && !token_out, "R1 after reset release", int'(tx_en), 0);
    for (int i = 0; i < 4; i++)
      for (int c = 0; c <= N_COL; c++)
        run_frame(ids[i], c, (i + c) % 2 == 1);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL R5 watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule